// File: doc/BRIEF.md
# Board-Dependent Display Control Register

This block holds one 32-bit display-control register that sits on a simple register bus next to the other system control registers of a board. A board-type parameter, fixed at build time, decides which bits software may change, which bits are read-only, what the register holds after reset, and whether a 2-bit pixel-format select is driven out to the display controller.

The reset value carries a read-only monitor identifier field in bits 13:8 (value 0x1F, meaning a VGA monitor) on the board types that implement the register. One board type (0x100) also copies the two low data bits of every write to the register onto a registered format-select output, which holds its value until the next write. Board type 0x190 and any board type not listed below leave the register unimplemented: it reads as zero and ignores writes.

The bus is a single-cycle strobe: a write takes effect at the clock edge where `bus_sel` and `bus_wr` are high and the address matches; read data is combinational while `bus_sel` is high, `bus_wr` is low and the address matches.

Top module: `dispctl_reg`

## Requirements
- R1: After reset the register reads 0x00001F00 for board types 0x100, 0x140, 0x178 and 0x182, and 0x00000000 for every other board type.
- R2: For board types 0x100 and 0x140 a write at the register offset replaces every bit except bits 13:8, which keep their value.
- R3: For board types 0x178 and 0x182 a write changes only bit 7; all other bits keep their reset value.
- R4: For board type 0x190 and any unlisted board type the register reads as zero and writes have no effect.
- R5: For board type 0x100 each write at the register offset puts write data bits 1:0 on `fmt_sel` from the next clock edge, and `fmt_sel` holds that value until the next such write.
- R6: `fmt_sel` is 0 after reset and stays 0 for every board type other than 0x100.
- R7: A write to any other offset (default offset 0x50 is the register) leaves the register and `fmt_sel` unchanged, and a read at any other offset returns zero.
- R8: `bus_rdata` shows the current register value during a read at the register offset and is zero when `bus_sel` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not a matching read |
| fmt_sel | output | 2 | Pixel-format select to the display controller |

## Verification
The bench builds six copies side by side with board types 0x100, 0x140, 0x178, 0x182, 0x190 and the unlisted 0x123, all driven by the same bus. Walking-one and walking-zero writes across all 32 bits, plus all-ones and all-zeros, expose every bit of every write mask, so a wrong read-only field, a wrong writable bit or a leaked write on an unimplemented board shows up in one sweep. The same writes drive the format select of every copy, which tests that only the 0x100 copy follows bits 1:0 and holds them.

// File: rtl/dispctl_reg.sv
module dispctl_reg #(
  parameter int                ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = 'h50,
  parameter logic [11:0]       BOARD   = 12'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [1:0]        fmt_sel
);

  localparam bit WIDE_MASK   = (BOARD == 12'h100) || (BOARD == 12'h140);
  localparam bit NARROW_MASK = (BOARD == 12'h178) || (BOARD == 12'h182);
  localparam bit HAS_MUX     = (BOARD == 12'h100);
  localparam logic [31:0] WMASK   = WIDE_MASK ? ~32'h0000_3F00 :
                                    NARROW_MASK ? 32'h0000_0080 : 32'h0;
  localparam logic [31:0] RST_VAL = (WIDE_MASK || NARROW_MASK) ? 32'h0000_1F00 : 32'h0;

  logic [31:0] ctl_q;
  logic        hit, wr_hit;

  assign hit       = bus_sel && (bus_addr == REG_OFS);
  assign wr_hit    = hit && bus_wr;
  assign bus_rdata = (hit && !bus_wr) ? ctl_q : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= RST_VAL;
    else if (wr_hit) ctl_q <= (ctl_q & ~WMASK) | (bus_wdata & WMASK);
  end

  // Bits outside the mask never move on a write (also covers R3).
  assert_ro_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_hit) |-> ((ctl_q & ~WMASK) == ($past(ctl_q) & ~WMASK)));

  assert_wr_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_hit) |-> ((ctl_q & WMASK) == ($past(bus_wdata) & WMASK)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hit) |-> $stable(ctl_q));

  assert_idle_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == 32'h0));

  generate
    if (HAS_MUX) begin : g_mux
      logic [1:0] sel_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= 2'b00;
        else if (wr_hit) sel_q <= bus_wdata[1:0];
      end
      assign fmt_sel = sel_q;

      assert_mux_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_hit) |-> (fmt_sel == $past(bus_wdata[1:0])));

      assert_mux_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_hit) |-> $stable(fmt_sel));
    end else begin : g_nomux
      assign fmt_sel = 2'b00;
    end

    if (!(WIDE_MASK || NARROW_MASK)) begin : g_raz
      assert_raz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata == 32'h0);
    end
  endgenerate

endmodule

// File: tb/sim_dispctl_reg.sv
`timescale 1ns/1ps
module sim_dispctl_reg;
  localparam int NB = 6;
  localparam logic [11:0] BT [NB] = '{12'h100, 12'h140, 12'h178, 12'h182, 12'h190, 12'h123};

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd [NB];
  logic [1:0]  fs [NB];

  logic [31:0] mdl [NB];
  logic [1:0]  mmux;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < NB; g++) begin : g_dut
    dispctl_reg #(.ADDR_W(12), .REG_OFS(12'h050), .BOARD(BT[g])) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(rd[g]), .fmt_sel(fs[g]));
  end

  function automatic logic [31:0] wmask(input logic [11:0] b);
    if (b == 12'h100 || b == 12'h140) return ~32'h0000_3F00;
    if (b == 12'h178 || b == 12'h182) return 32'h0000_0080;
    return 32'h0;
  endfunction

  function automatic logic [31:0] rstval(input logic [11:0] b);
    if (b == 12'h100 || b == 12'h140 || b == 12'h178 || b == 12'h182) return 32'h0000_1F00;
    return 32'h0;
  endfunction

  function automatic string req_of(input logic [11:0] b);
    if (b == 12'h100 || b == 12'h140) return "R2";
    if (b == 12'h178 || b == 12'h182) return "R3";
    return "R4";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (a == 12'h050) begin
      for (int i = 0; i < NB; i++) mdl[i] = (mdl[i] & ~wmask(BT[i])) | (d & wmask(BT[i]));
      mmux = d[1:0];
    end
  endtask

  task automatic check_all(input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = 12'h050;
    #1;
    for (int i = 0; i < NB; i++) begin
      check({req_of(BT[i]), " ", tag}, rd[i], mdl[i]);
      if (i == 0) check({"R5 ", tag}, {30'd0, fs[i]}, {30'd0, mmux});
      else        check({"R6 ", tag}, {30'd0, fs[i]}, 32'h0);
    end
    bus_sel = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) mdl[i] = rstval(BT[i]);
    mmux = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 and R6: reset state
    bus_sel = 1; bus_wr = 0; bus_addr = 12'h050; #1;
    for (int i = 0; i < NB; i++) begin
      check("R1 reset value", rd[i], rstval(BT[i]));
      check("R6 reset mux", {30'd0, fs[i]}, 32'h0);
    end
    bus_sel = 0;

    // R8: no select gives zero read data
    bus_addr = 12'h050; #1;
    for (int i = 0; i < NB; i++) check("R8 idle read", rd[i], 32'h0);

    for (int b = 0; b < 32; b++) begin
      bus_write(12'h050, 32'h1 << b);
      check_all("walk one");
      bus_write(12'h050, ~(32'h1 << b));
      check_all("walk zero");
    end
    bus_write(12'h050, 32'hFFFF_FFFF); check_all("all ones");
    bus_write(12'h050, 32'h0000_0000); check_all("all zeros");
    bus_write(12'h050, 32'hA5C3_96E2); check_all("mixed");

    // R7: other offsets neither write nor read the register
    bus_write(12'h054, 32'hFFFF_FFFF); check_all("R7 other write");
    bus_write(12'h04C, 32'h0000_0001); check_all("R7 other write");
    bus_write(12'h150, 32'h0000_0003); check_all("R7 alias write");
    bus_sel = 1; bus_wr = 0; bus_addr = 12'h054; #1;
    for (int i = 0; i < NB; i++) check("R7 other read", rd[i], 32'h0);
    bus_sel = 0;

    // R5: mux holds across idle cycles
    bus_write(12'h050, 32'h0000_0002);
    repeat (5) @(negedge clk);
    check_all("R5 hold");

    // R8: read shows current value after a final write
    bus_write(12'h050, 32'h1234_5679);
    check_all("R8 readback");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule